// File: doc/BRIEF.md
# Serial Port Control and Status Register Bank

This block is the register front end of a FIFO-based serial port. It sits on a simple word-addressed bus and holds the configuration registers: mode, baud divisor, control, FIFO control and port. It also keeps the five status flags: transmit-end, transmit-empty, break, receive-full and data-ready. Bit timing, baud generation and receive FIFO storage belong to neighbouring blocks. Those blocks feed this one with single-cycle event pulses, the current receive byte and the receive fill level.

A flag is cleared by writing 0 to its status bit. Writing 1 to a status bit leaves it alone. While transmit is enabled, a status read returns the current flags and then re-arms transmit-end and transmit-empty. A write to the transmit data offset produces a one-cycle strobe carrying the byte. The block drives the transmit and receive interrupt lines. It also gives the receive side a threshold level, a FIFO clear strobe and a pop strobe.

Top module: `sci_csr_top`

## Requirements
- R1: After reset the registers hold these values. Baud is 0xFF. Control is 0x20. Mode, port and FIFO control are 0. Transmit-end and transmit-empty are 1 and the other flags are 0. Both interrupt lines are low, and the threshold level is 1.
- R2: `bus_word` is the byte offset divided by 4. Word 0 reads mode, 1 baud, 2 control, 4 status, 5 receive byte, 6 FIFO control, 7 receive level and 8 port. Word 3 (transmit data), word 9 (line status) and words 10 to 15 read as 0. Writes to words 5, 7, 9 and 10 to 15 change nothing. Read data is valid in the cycle the read is presented.
- R3: Writes are masked before they are stored: mode with 0x7B, control with 0xFA and port with 0xF3. Baud and FIFO control store the full written value.
- R4: The status word carries transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. All other bits are 0. A status write clears each of these flags whose bit is 0 and keeps each whose bit is 1.
- R5: A status read returns the flags as they stood before the read. If control bit 5 (transmit enable) is 1, transmit-end and transmit-empty are both 1 from the next cycle on. If control bit 5 is 0, the read changes no flag.
- R6: A control write with bit 5 at 0 sets transmit-end.
- R7: A transmit data write clears transmit-empty. It raises `tx_stb` for exactly the next cycle, with `tx_byte` holding the written low byte.
- R8: `tx_irq` takes the value of control bit 7 on every control write and holds it otherwise.
- R9: A full-threshold pulse raises `rx_irq` when receive interrupt enable (control bit 6) is 1. On a control write in the same cycle, the new bit 6 decides. `rx_irq` falls after a control write with bit 6 at 0, or after a status write with bit 1 or bit 0 at 0. A full pulse in the same cycle as such a status write wins.
- R10: A break pulse sets break, a full-threshold pulse sets receive-full and a data-ready pulse sets data-ready. Each set wins over a clearing status write in the same cycle.
- R11: A read of word 5 returns `rx_data` and raises `rx_pop` in that cycle only. A read of word 7 returns `rx_level`.
- R12: `rx_trig` is 1, 4, 8 or 14 for FIFO control bits [7:6] equal to 0, 1, 2 or 3. A FIFO control write with bit 1 at 1 raises `fifo_clr` for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | IDX_W | Word offset (byte offset / 4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational during a read |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_level | input | CNT_W | Receive FIFO fill level |
| rx_full_evt | input | 1 | Pulse: receive threshold reached |
| rx_break_evt | input | 1 | Pulse: break detected |
| rx_dr_evt | input | 1 | Pulse: receive data ready |
| rx_pop | output | 1 | Receive byte read this cycle |
| rx_trig | output | 5 | Receive threshold level |
| fifo_clr | output | 1 | One-cycle receive FIFO clear |
| tx_stb | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Status writes are applied with all-ones, all-zeros and random masks. This separates clear-on-zero from clear-on-one and from a write that is wrongly ignored. Status reads are issued twice in a row, with transmit enable both on and off. The pair shows that the returned word is the old one and that re-arming happens only when transmit is enabled. Event pulses are driven in the same cycle as clearing writes and as control writes. These cases fix the set-wins rule and the choice between the new and the stored receive-enable bit. A long random mix of reads, writes, events and unmapped offsets is compared with a bench model after every access.

// File: rtl/sci_csr_pkg.sv
package sci_csr_pkg;

  // Word offsets; the receive and transmit neighbours rely on these positions.
  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_BAUD = 1;
  localparam int unsigned REG_CTRL = 2;
  localparam int unsigned REG_TXD  = 3;
  localparam int unsigned REG_STAT = 4;
  localparam int unsigned REG_RXD  = 5;
  localparam int unsigned REG_FCTL = 6;
  localparam int unsigned REG_RCNT = 7;
  localparam int unsigned REG_PORT = 8;
  localparam int unsigned REG_LINE = 9;
  localparam int unsigned NUM_REGS = 10;

  localparam logic [7:0] MODE_MASK = 8'h7B;
  localparam logic [7:0] CTRL_MASK = 8'hFA;
  localparam logic [7:0] PORT_MASK = 8'hF3;
  localparam logic [7:0] BAUD_RST  = 8'hFF;
  localparam logic [7:0] CTRL_RST  = 8'h20;

  localparam int unsigned CTRL_TXEN = 5;
  localparam int unsigned CTRL_RIE  = 6;
  localparam int unsigned CTRL_TIE  = 7;

  localparam int unsigned ST_TEND = 6;
  localparam int unsigned ST_TDE  = 5;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_RDF  = 1;
  localparam int unsigned ST_DR   = 0;

  localparam int unsigned FCTL_CLR = 1;

  typedef struct packed {
    logic tend;
    logic tde;
    logic brk;
    logic rdf;
    logic dr;
  } stat_t;

  localparam stat_t STAT_RST = '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rdf: 1'b0, dr: 1'b0};

  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  function automatic logic [7:0] stat_byte(input stat_t f);
    logic [7:0] b;
    b = 8'h00;
    b[ST_TEND] = f.tend;
    b[ST_TDE]  = f.tde;
    b[ST_BRK]  = f.brk;
    b[ST_RDF]  = f.rdf;
    b[ST_DR]   = f.dr;
    return b;
  endfunction

endpackage

// File: rtl/sci_csr_decode.sv
module sci_csr_decode
  import sci_csr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                acc_sel,
  input  logic                acc_wr,
  input  logic [IDX_W-1:0]    acc_idx,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    logic match;
    assign match     = (acc_idx == IDX_W'(g));
    assign wr_hit[g] = acc_sel &  acc_wr & match;
    assign rd_hit[g] = acc_sel & ~acc_wr & match;
  end

endmodule

// File: rtl/sci_csr_cfg.sv
module sci_csr_cfg
  import sci_csr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              baud_we,
  input  logic              ctrl_we,
  input  logic              fctl_we,
  input  logic              port_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        mode_q,
  output logic [7:0]        baud_q,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        port_q,
  output logic [DATA_W-1:0] fctl_q,
  output logic              fifo_clr
);

  logic [7:0] mode_d, ctrl_d, port_d;
  logic       clr_d;

  always_comb begin
    mode_d = wdata[7:0] & MODE_MASK;
    ctrl_d = wdata[7:0] & CTRL_MASK;
    port_d = wdata[7:0] & PORT_MASK;
    clr_d  = fctl_we & wdata[FCTL_CLR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 8'h00;
      baud_q   <= BAUD_RST;
      ctrl_q   <= CTRL_RST;
      port_q   <= 8'h00;
      fctl_q   <= '0;
      fifo_clr <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_d;
      if (baud_we) baud_q <= wdata[7:0];
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (port_we) port_q <= port_d;
      if (fctl_we) fctl_q <= wdata;
      fifo_clr <= clr_d;
    end
  end

endmodule

// File: rtl/sci_csr_flags.sv
module sci_csr_flags
  import sci_csr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  logic  txen_new,
  input  logic  txen_q,
  input  logic  stat_we,
  input  stat_t stat_keep,
  input  logic  stat_re,
  input  logic  txd_we,
  input  logic  brk_evt,
  input  logic  full_evt,
  input  logic  dr_evt,
  output stat_t flags_q
);

  stat_t set_v, clr_v, flags_d;
  logic  rearm;

  always_comb begin
    rearm = stat_re & txen_q;

    set_v.tend = (ctrl_we & ~txen_new) | rearm;
    set_v.tde  = rearm;
    set_v.brk  = brk_evt;
    set_v.rdf  = full_evt;
    set_v.dr   = dr_evt;

    clr_v.tend = stat_we & ~stat_keep.tend;
    clr_v.tde  = (stat_we & ~stat_keep.tde) | txd_we;
    clr_v.brk  = stat_we & ~stat_keep.brk;
    clr_v.rdf  = stat_we & ~stat_keep.rdf;
    clr_v.dr   = stat_we & ~stat_keep.dr;

    // A set in the same cycle as a clear wins.
    flags_d = stat_t'(set_v | (flags_q & ~clr_v));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= STAT_RST;
    else        flags_q <= flags_d;
  end

endmodule

// File: rtl/sci_csr_irq.sv
module sci_csr_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic       tie_new,
  input  logic       rie_new,
  input  logic       rie_q,
  input  logic       stat_we,
  input  logic       stat_keep_rx,
  input  logic       full_evt,
  input  logic       txd_we,
  input  logic [7:0] txd_byte,
  output logic       tx_irq,
  output logic       rx_irq,
  output logic       tx_stb,
  output logic [7:0] tx_byte
);

  logic rie_eff, rx_set, rx_clr, rx_irq_d, tx_irq_d;

  always_comb begin
    rie_eff  = ctrl_we ? rie_new : rie_q;
    rx_set   = full_evt & rie_eff;
    rx_clr   = (ctrl_we & ~rie_new) | (stat_we & ~stat_keep_rx);
    rx_irq_d = rx_set | (rx_irq & ~rx_clr);
    tx_irq_d = ctrl_we ? tie_new : tx_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_irq  <= 1'b0;
      rx_irq  <= 1'b0;
      tx_stb  <= 1'b0;
      tx_byte <= 8'h00;
    end else begin
      tx_irq <= tx_irq_d;
      rx_irq <= rx_irq_d;
      tx_stb <= txd_we;
      if (txd_we) tx_byte <= txd_byte;
    end
  end

endmodule

// File: rtl/sci_csr_top.sv
module sci_csr_top
  import sci_csr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rx_data,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_full_evt,
  input  logic              rx_break_evt,
  input  logic              rx_dr_evt,
  output logic              rx_pop,
  output logic [4:0]        rx_trig,
  output logic              fifo_clr,
  output logic              tx_stb,
  output logic [7:0]        tx_byte,
  output logic              tx_irq,
  output logic              rx_irq
);

  logic [NUM_REGS-1:0] wr_hit, rd_hit;
  logic [7:0]          mode_q, baud_q, ctrl_q, port_q;
  logic [DATA_W-1:0]   fctl_q;
  stat_t               flags_q, stat_keep;
  logic                txen_q;
  logic                unused_hits;

  sci_csr_decode #(.IDX_W(IDX_W)) u_dec (
    .acc_sel (bus_sel),
    .acc_wr  (bus_wr),
    .acc_idx (bus_word),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  sci_csr_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_we  (wr_hit[REG_MODE]),
    .baud_we  (wr_hit[REG_BAUD]),
    .ctrl_we  (wr_hit[REG_CTRL]),
    .fctl_we  (wr_hit[REG_FCTL]),
    .port_we  (wr_hit[REG_PORT]),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .baud_q   (baud_q),
    .ctrl_q   (ctrl_q),
    .port_q   (port_q),
    .fctl_q   (fctl_q),
    .fifo_clr (fifo_clr)
  );

  assign txen_q = ctrl_q[CTRL_TXEN];

  always_comb begin
    stat_keep.tend = bus_wdata[ST_TEND];
    stat_keep.tde  = bus_wdata[ST_TDE];
    stat_keep.brk  = bus_wdata[ST_BRK];
    stat_keep.rdf  = bus_wdata[ST_RDF];
    stat_keep.dr   = bus_wdata[ST_DR];
  end

  sci_csr_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (wr_hit[REG_CTRL]),
    .txen_new  (bus_wdata[CTRL_TXEN]),
    .txen_q    (txen_q),
    .stat_we   (wr_hit[REG_STAT]),
    .stat_keep (stat_keep),
    .stat_re   (rd_hit[REG_STAT]),
    .txd_we    (wr_hit[REG_TXD]),
    .brk_evt   (rx_break_evt),
    .full_evt  (rx_full_evt),
    .dr_evt    (rx_dr_evt),
    .flags_q   (flags_q)
  );

  sci_csr_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_we      (wr_hit[REG_CTRL]),
    .tie_new      (bus_wdata[CTRL_TIE]),
    .rie_new      (bus_wdata[CTRL_RIE]),
    .rie_q        (ctrl_q[CTRL_RIE]),
    .stat_we      (wr_hit[REG_STAT]),
    .stat_keep_rx (bus_wdata[ST_RDF] & bus_wdata[ST_DR]),
    .full_evt     (rx_full_evt),
    .txd_we       (wr_hit[REG_TXD]),
    .txd_byte     (bus_wdata[7:0]),
    .tx_irq       (tx_irq),
    .rx_irq       (rx_irq),
    .tx_stb       (tx_stb),
    .tx_byte      (tx_byte)
  );

  // Read-only and unmapped offsets have no consumer for their strobes.
  assign unused_hits = ^{wr_hit[REG_RXD], wr_hit[REG_RCNT], wr_hit[REG_LINE],
                         rd_hit[REG_TXD], rd_hit[REG_LINE]};

  always_comb begin
    bus_rdata = '0;
    if (rd_hit[REG_MODE]) bus_rdata = DATA_W'(mode_q);
    if (rd_hit[REG_BAUD]) bus_rdata = DATA_W'(baud_q);
    if (rd_hit[REG_CTRL]) bus_rdata = DATA_W'(ctrl_q);
    if (rd_hit[REG_STAT]) bus_rdata = DATA_W'(stat_byte(flags_q));
    if (rd_hit[REG_RXD])  bus_rdata = DATA_W'(rx_data);
    if (rd_hit[REG_FCTL]) bus_rdata = fctl_q;
    if (rd_hit[REG_RCNT]) bus_rdata = DATA_W'(rx_level);
    if (rd_hit[REG_PORT]) bus_rdata = DATA_W'(port_q);
  end

  assign rx_pop  = rd_hit[REG_RXD];
  assign rx_trig = trig_level(fctl_q[7:6]);

endmodule

// File: rtl/sci_csr_chk.sv
module sci_csr_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_sel,
  input logic             acc_wr,
  input logic [IDX_W-1:0] acc_idx,
  input logic [7:0]       wdata_lo,
  input logic             brk_evt,
  input logic             full_evt,
  input logic             dr_evt,
  input logic             tx_stb,
  input logic [7:0]       tx_byte,
  input logic             tx_irq,
  input logic             rx_irq,
  input logic [4:0]       flags,
  input logic             txen_q
);

  // flags: [4]=tx end, [3]=tx empty, [2]=break, [1]=rx full, [0]=data ready
  logic w_ctrl, w_txd, w_stat, r_stat, quiet;
  assign w_ctrl = acc_sel &  acc_wr & (acc_idx == IDX_W'(2));
  assign w_txd  = acc_sel &  acc_wr & (acc_idx == IDX_W'(3));
  assign w_stat = acc_sel &  acc_wr & (acc_idx == IDX_W'(4));
  assign r_stat = acc_sel & ~acc_wr & (acc_idx == IDX_W'(4));
  assign quiet  = ~brk_evt & ~full_evt & ~dr_evt;

  assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_txd |=> tx_stb && (tx_byte == $past(wdata_lo)));
  assert_no_stray_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !w_txd |=> !tx_stb);
  assert_tde_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_txd |=> !flags[3]);
  assert_tend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !wdata_lo[5]) |=> flags[4]);
  assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stat && txen_q) |=> (flags[4] && flags[3]));
  assert_read_no_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_stat && !txen_q && quiet) |=> $stable(flags));
  assert_keep_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && wdata_lo[6] && wdata_lo[5] && wdata_lo[4] && wdata_lo[1] && wdata_lo[0] && quiet)
    |=> $stable(flags));
  assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_sel && quiet) |=> $stable(flags));
  assert_tie_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    w_ctrl |=> (tx_irq == $past(wdata_lo[7])));
  assert_rie_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !wdata_lo[6]) |=> !rx_irq);
  assert_brk_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> flags[2]);
  assert_full_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full_evt |=> flags[1]);
  assert_dr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dr_evt |=> flags[0]);

endmodule

bind sci_csr_top sci_csr_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_sel  (bus_sel),
  .acc_wr   (bus_wr),
  .acc_idx  (bus_word),
  .wdata_lo (bus_wdata[7:0]),
  .brk_evt  (rx_break_evt),
  .full_evt (rx_full_evt),
  .dr_evt   (rx_dr_evt),
  .tx_stb   (tx_stb),
  .tx_byte  (tx_byte),
  .tx_irq   (tx_irq),
  .rx_irq   (rx_irq),
  .flags    (flags_q),
  .txen_q   (txen_q)
);

// File: tb/sim_sci_csr_top.sv
`timescale 1ns/1ps
module sim_sci_csr_top;

  localparam int IDX_W  = 4;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [IDX_W-1:0]  bus_word;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic [7:0]        rx_data;
  logic [CNT_W-1:0]  rx_level;
  logic              rx_full_evt, rx_break_evt, rx_dr_evt;
  logic              rx_pop, fifo_clr, tx_stb, tx_irq, rx_irq;
  logic [4:0]        rx_trig;
  logic [7:0]        tx_byte;

  always #10 clk = ~clk;

  sci_csr_top #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (.*);

  int n_chk = 0;
  int n_err = 0;

  // Bench model of the programmer-visible state.
  logic [7:0]        m_mode, m_baud, m_ctrl, m_port;
  logic [DATA_W-1:0] m_fctl;
  logic              m_tend, m_tde, m_brk, m_rdf, m_dr;
  logic              m_txirq, m_rxirq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_stat();
    return {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
  endfunction

  function automatic logic [4:0] m_trig(input logic [1:0] c);
    case (c)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] m_read(input int w, input logic [7:0] rd, input logic [CNT_W-1:0] lv);
    case (w)
      0: return DATA_W'(m_mode);
      1: return DATA_W'(m_baud);
      2: return DATA_W'(m_ctrl);
      4: return DATA_W'(m_stat());
      5: return DATA_W'(rd);
      6: return m_fctl;
      7: return DATA_W'(lv);
      8: return DATA_W'(m_port);
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 8'h00; m_baud = 8'hFF; m_ctrl = 8'h20; m_port = 8'h00; m_fctl = '0;
    m_tend = 1'b1; m_tde = 1'b1; m_brk = 1'b0; m_rdf = 1'b0; m_dr = 1'b0;
    m_txirq = 1'b0; m_rxirq = 1'b0;
  endtask

  // One bus cycle with optional event pulses, checked against the model.
  task automatic cyc(input string tag, input logic sel, input logic wr, input int w,
                     input logic [DATA_W-1:0] d, input logic brk, input logic full, input logic dre);
    logic cw, tw, sw, sr, fw, set_en, rclr, exp_stb, exp_clr;
    logic [7:0] rd;
    logic [CNT_W-1:0] lv;
    @(negedge clk);
    rd = 8'($urandom);
    lv = CNT_W'($urandom_range(16, 0));
    bus_sel = sel; bus_wr = wr; bus_word = IDX_W'(w); bus_wdata = d;
    rx_break_evt = brk; rx_full_evt = full; rx_dr_evt = dre;
    rx_data = rd; rx_level = lv;
    #1;
    if (sel && !wr) chk({tag, " rdata"}, 32'(bus_rdata), 32'(m_read(w, rd, lv)));
    chk({tag, " rx_pop R11"}, 32'(rx_pop), 32'(sel && !wr && w == 5));

    cw = sel && wr && w == 2;
    tw = sel && wr && w == 3;
    sw = sel && wr && w == 4;
    fw = sel && wr && w == 6;
    sr = sel && !wr && w == 4;

    set_en  = cw ? d[6] : m_ctrl[6];
    rclr    = (cw && !d[6]) || (sw && !(d[1] && d[0]));
    m_rxirq = (full && set_en) || (m_rxirq && !rclr);

    if (cw && !d[5]) m_tend = 1'b1;
    if (sw) begin
      m_tend &= d[6]; m_tde &= d[5]; m_brk &= d[4]; m_rdf &= d[1]; m_dr &= d[0];
    end
    if (tw) m_tde = 1'b0;
    if (sr && m_ctrl[5]) begin m_tend = 1'b1; m_tde = 1'b1; end
    if (brk)  m_brk = 1'b1;
    if (full) m_rdf = 1'b1;
    if (dre)  m_dr  = 1'b1;

    if (cw) begin m_txirq = d[7]; m_ctrl = d[7:0] & 8'hFA; end
    if (sel && wr && w == 0) m_mode = d[7:0] & 8'h7B;
    if (sel && wr && w == 1) m_baud = d[7:0];
    if (sel && wr && w == 8) m_port = d[7:0] & 8'hF3;
    if (fw) m_fctl = d;
    exp_stb = tw;
    exp_clr = fw && d[1];

    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rx_break_evt = 1'b0; rx_full_evt = 1'b0; rx_dr_evt = 1'b0;
    chk({tag, " tx_stb R7"}, 32'(tx_stb), 32'(exp_stb));
    if (exp_stb) chk({tag, " tx_byte R7"}, 32'(tx_byte), 32'(d[7:0]));
    chk({tag, " tx_irq R8"}, 32'(tx_irq), 32'(m_txirq));
    chk({tag, " rx_irq R9"}, 32'(rx_irq), 32'(m_rxirq));
    chk({tag, " fifo_clr R12"}, 32'(fifo_clr), 32'(exp_clr));
    chk({tag, " rx_trig R12"}, 32'(rx_trig), 32'(m_trig(m_fctl[7:6])));
  endtask

  task automatic rd(input string tag, input int w);
    cyc(tag, 1'b1, 1'b0, w, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input int w, input logic [DATA_W-1:0] d);
    cyc(tag, 1'b1, 1'b1, w, d, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C5A));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0;
    rx_data = 8'h00; rx_level = '0;
    rx_full_evt = 1'b0; rx_break_evt = 1'b0; rx_dr_evt = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values through every readable offset
    chk("R1 tx_irq", 32'(tx_irq), 32'd0);
    chk("R1 rx_irq", 32'(rx_irq), 32'd0);
    chk("R1 rx_trig", 32'(rx_trig), 32'd1);
    for (int w = 0; w < 10; w++) rd("R1 reset read", w);

    // R3: write masks
    wr("R3 mode mask", 0, 16'h00FF); rd("R3 mode read", 0);
    wr("R3 port mask", 8, 16'h00FF); rd("R3 port read", 8);
    wr("R3 ctrl mask", 2, 16'h00FF); rd("R3 ctrl read", 2);
    wr("R3 ctrl restore", 2, 16'h0020);

    // R2: map, ignored writes, zero reads
    wr("R2 baud", 1, 16'h005A); rd("R2 baud read", 1);
    wr("R2 line write ignored", 9, 16'hFFFF); rd("R2 line read", 9);
    wr("R2 unmapped write", 11, 16'hFFFF); rd("R2 unmapped read", 11);
    wr("R2 fctl full width", 6, 16'hA500); rd("R2 fctl read", 6);

    // R7 and R5: transmit write, then two status reads with transmit enabled
    wr("R7 txd write", 3, 16'h00A5);
    rd("R5 status old value", 4);
    rd("R5 status rearmed", 4);
    rd("R2 txd reads zero", 3);

    // R4: clear-by-zero, keep-by-one
    wr("R4 status keep ones", 4, 16'h00FF); rd("R4 after keep", 4);
    wr("R2 ctrl txen off", 2, 16'h0000);
    wr("R4 status clear all", 4, 16'h0000); rd("R4 after clear", 4);
    rd("R5 read no rearm", 4); rd("R5 read no rearm again", 4);

    // R6: control write without transmit enable sets tx end
    wr("R6 ctrl bit5 low", 2, 16'h0000); rd("R6 status", 4);

    // R10: sets win over same-cycle clears
    cyc("R10 brk vs clear", 1'b1, 1'b1, 4, 16'h0000, 1'b1, 1'b0, 1'b0); rd("R10 read brk", 4);
    cyc("R10 full vs clear", 1'b1, 1'b1, 4, 16'h0000, 1'b0, 1'b1, 1'b0); rd("R10 read full", 4);
    cyc("R10 dr vs clear", 1'b1, 1'b1, 4, 16'h0000, 1'b0, 1'b0, 1'b1); rd("R10 read dr", 4);

    // R9: receive interrupt set/clear
    cyc("R9 full disabled", 1'b0, 1'b0, 0, '0, 1'b0, 1'b1, 1'b0);
    wr("R9 enable rie", 2, 16'h0040);
    cyc("R9 full enabled", 1'b0, 1'b0, 0, '0, 1'b0, 1'b1, 1'b0);
    wr("R9 status keep rx", 4, 16'h0003);
    wr("R9 status clear bit0", 4, 16'h00FE);
    cyc("R9 full enabled again", 1'b0, 1'b0, 0, '0, 1'b0, 1'b1, 1'b0);
    cyc("R9 full vs status clear", 1'b1, 1'b1, 4, 16'h00FD, 1'b0, 1'b1, 1'b0);
    wr("R9 ctrl rie off", 2, 16'h0000);
    cyc("R9 full with new rie on", 1'b1, 1'b1, 2, 16'h0040, 1'b0, 1'b1, 1'b0);
    cyc("R9 full with new rie off", 1'b1, 1'b1, 2, 16'h0000, 1'b0, 1'b1, 1'b0);

    // R8: transmit interrupt follows control bit 7
    wr("R8 tie on", 2, 16'h0080);
    cyc("R8 hold", 1'b0, 1'b0, 0, '0, 1'b0, 1'b0, 1'b0);
    wr("R8 tie off", 2, 16'h0000);

    // R11: receive byte and level
    rd("R11 rx byte", 5); rd("R11 rx level", 7);

    // R12: threshold codes and clear strobe
    for (int c = 0; c < 4; c++) wr("R12 trig code", 6, DATA_W'(c << 6));
    wr("R12 fifo clear", 6, 16'h0042);

    // Random mix (R2..R12 via the model)
    for (int i = 0; i < 1500; i++) begin
      int op, w;
      logic [DATA_W-1:0] d;
      logic b, f, r;
      op = $urandom_range(3, 0);
      w  = $urandom_range(11, 0);
      d  = DATA_W'($urandom);
      if (w == 4 && $urandom_range(1, 0) == 1) d[7:0] = 8'hFF;
      b = ($urandom_range(7, 0) == 0);
      f = ($urandom_range(5, 0) == 0);
      r = ($urandom_range(7, 0) == 0);
      case (op)
        0: cyc("R2 random write", 1'b1, 1'b1, w, d, 1'b0, 1'b0, 1'b0);
        1: cyc("R2 random read", 1'b1, 1'b0, w, '0, 1'b0, 1'b0, 1'b0);
        2: cyc("R10 random events", 1'b0, 1'b0, 0, '0, b, f, r);
        default: cyc("R9 random mixed", 1'b1, $urandom_range(1, 0) == 1, w, d, b, f, r);
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule